// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects up to several hundred hardware interrupt lines, organised in banks of 32, and presents two requests to a processor: a normal request and a fast request. Each line has its own configuration word that selects its priority, whether it is edge- or level-sensitive, and which of the two requests it feeds. Each line also has a per-line mask bit. Lines that are pending, unmasked and routed to a request compete. The lowest priority value wins. When priorities are equal, the higher global line number wins.

The two requests follow a one-shot agreement scheme. A request is raised when its agreement flag is set and at least one line is eligible. At that moment the winning line number is latched and the flag is cleared. The request then stays high until software writes the control register to re-arm it. Software reads a source-code register to learn which line fired, and that read also acknowledges an edge-type line. All access goes through a simple synchronous register bus. Bits above offset bit 7 select the bank. Hardware inputs pass through a configurable synchronizer before edge detection.

Top module: `intc_banked`

## Requirements
- R1: After reset every mask bit reads 1, pending reads 0, both requests are low, and both source codes read 0.
- R2: A per-line configuration word at bank offset 0x1C + 4*line holds the priority in bits [6:2], the sensitivity in bit 1 (1 = level, 0 = edge) and the fast-request routing in bit 0. It reads back with every higher bit as 0.
- R3: An edge-type line becomes pending only on a low-to-high input transition. Pending shows on the third rising clock edge after the input changes, and it stays set after the input falls. Holding the input high does not set it again once it has been cleared.
- R4: A level-type line is pending while its input is high, and its pending bit clears when the input falls.
- R5: A write to the pending register (offset 0x00) ANDs each bit with the written value. A bit of a level-type line whose input is high stays set.
- R6: Among pending, unmasked lines routed to a request, across all banks, the lowest priority value wins, and on a tie the higher global line number wins. Lines routed to the other request are not considered.
- R7: A request rises only while its agreement flag is set and a line is eligible. It then latches the winner and stays high, with the same latched code, until it is re-armed. This holds even if a better line appears.
- R8: Writing the control register (bank 0, offset 0x18) with bit 0 (normal) or bit 1 (fast) drops that request on the next edge and re-arms it. The request rises again one cycle later if a line is eligible, and otherwise it stays low.
- R9: Reading a source-code register (bank 0, offset 0x10 normal, 0x14 fast) returns the latched line index within its bank in bits [4:0]. If that line is edge-type, the read clears its pending bit. A level-type line is not cleared.
- R10: Control and source-code reads in banks other than 0, and reads of unmapped offsets, return 0 and change no state.
- R11: A write to the software-set register (offset 0x9C) sets pending only for the lowest set bit of the written value, in the addressed bank.
- R12: The mask register (offset 0x04) reads back what was written. The software-set register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NBANKS*32 | Hardware interrupt lines, global line n at bit n |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears in bus_rdata after the edge |
| bus_addr | input | 8+BANK_W | Byte address; bits above 7 select the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with two banks and a two-stage synchronizer. With two banks, arbitration has to span the bank boundary, so winners above line 31 return a code truncated to the in-bank index. Two banks also make the bank-1 copies of the control and source-code offsets reachable, and those must stay inert. The two-stage synchronizer fixes the input-to-pending latency that the bench samples against.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
   localparam int unsigned LINES_PER_BANK = 32;
   localparam int unsigned PRIO_W         = 5;

   localparam logic [7:0] OFS_PEND     = 8'h00;
   localparam logic [7:0] OFS_MASK     = 8'h04;
   localparam logic [7:0] OFS_CODE_NRM = 8'h10;
   localparam logic [7:0] OFS_CODE_FST = 8'h14;
   localparam logic [7:0] OFS_CTRL     = 8'h18;
   localparam logic [7:0] OFS_CFG0     = 8'h1C;
   localparam logic [7:0] OFS_CFG_LAST = 8'h98;
   localparam logic [7:0] OFS_SOFT     = 8'h9C;

   // layout matches the per-line configuration word bits [6:0]
   typedef struct packed {
      logic [PRIO_W-1:0] prio;
      logic              level;
      logic              to_fast;
   } line_cfg_t;
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
   parameter int unsigned W      = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("intc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q <= '0;
         else        stage_q <= d;
      end
      assign q = stage_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
   import intc_pkg::*;
(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [LINES_PER_BANK-1:0]        in_sync,
   input  logic                             wr_pend,
   input  logic                             wr_mask,
   input  logic                             wr_cfg,
   input  logic                             wr_soft,
   input  logic [4:0]                       cfg_idx,
   input  logic [31:0]                      wdata,
   input  logic [LINES_PER_BANK-1:0]        ack_clr,
   output logic [LINES_PER_BANK-1:0]        pend_o,
   output logic [LINES_PER_BANK-1:0]        mask_o,
   output logic [LINES_PER_BANK-1:0]        level_o,
   output logic [LINES_PER_BANK-1:0]        fast_o,
   output logic [LINES_PER_BANK*PRIO_W-1:0] prio_o
);
   localparam int unsigned L = LINES_PER_BANK;

   logic [L-1:0] pend_q, mask_q, in_prev_q;
   line_cfg_t    cfg_q [L];
   logic [L-1:0] lvl_v, rise_v, fall_v, lvl_high, soft_v, set_v, clr_v;

   always_comb begin
      for (int i = 0; i < int'(L); i++) begin
         lvl_v[i]                 = cfg_q[i].level;
         fast_o[i]                = cfg_q[i].to_fast;
         prio_o[i*PRIO_W +: PRIO_W] = cfg_q[i].prio;
      end
   end

   assign rise_v   = in_sync & ~in_prev_q;
   assign fall_v   = ~in_sync & in_prev_q;
   assign lvl_high = lvl_v & in_sync;
   // isolate lowest set bit of the software-set word
   assign soft_v   = wr_soft ? (wdata & (~wdata + 32'd1)) : '0;
   assign set_v    = (~lvl_v & rise_v) | lvl_high | soft_v;
   assign clr_v    = (lvl_v & fall_v) | (~lvl_v & ack_clr) | (wr_pend ? ~wdata : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         mask_q    <= '1;
         in_prev_q <= '0;
         for (int i = 0; i < int'(L); i++) cfg_q[i] <= '0;
      end else begin
         pend_q    <= (pend_q & ~clr_v) | set_v;
         in_prev_q <= in_sync;
         if (wr_mask) mask_q <= wdata;
         if (wr_cfg)  cfg_q[cfg_idx] <= line_cfg_t'(wdata[6:0]);
      end
   end

   assign pend_o  = pend_q;
   assign mask_o  = mask_q;
   assign level_o = lvl_v;

   // R4, R5: a high level-type input is pending on the following edge whatever else happens
   a_r4_level_high_pends: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(lvl_high)) == $past(lvl_high)));

   // R3: a newly pending line needs an edge-type rise, a level-high input or a software set
   a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & $past(~lvl_high & ~(~lvl_v & rise_v) & ~soft_v)) == '0));

   // R11: at most one line per software-set write
   a_r11_single_soft: assert property (@(posedge clk) disable iff (!rst_n)
      wr_soft |-> $onehot0(soft_v));
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int unsigned N = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          elig,
   input  logic [N*PRIO_W-1:0]   prio,
   output logic                  any_o,
   output logic [$clog2(N)-1:0]  win_o
);
   localparam int unsigned IW = $clog2(N);

   logic [PRIO_W-1:0] best;

   // scan upward; "<=" lets a later (higher) line take an equal priority
   always_comb begin
      best  = '1;
      win_o = '0;
      any_o = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (elig[i] && (prio[i*PRIO_W +: PRIO_W] <= best)) begin
            best  = prio[i*PRIO_W +: PRIO_W];
            win_o = IW'(i);
            any_o = 1'b1;
         end
      end
   end

   a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> elig[win_o]);

   a_r6_idle_without_candidates: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> !any_o);
endmodule

// File: rtl/intc_banked.sv
`timescale 1ns/1ps
module intc_banked
   import intc_pkg::*;
#(
   parameter  int unsigned NBANKS      = 2,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned BANK_W      = (NBANKS > 1) ? $clog2(NBANKS) : 1,
   localparam int unsigned ADDR_W      = 8 + BANK_W,
   localparam int unsigned NLINES      = NBANKS * LINES_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out,
   output logic              fiq_out
);
   localparam int unsigned IDX_W = $clog2(NLINES);

   if (NBANKS < 1 || NBANKS > 8) begin : g_bad_banks
      $error("intc_banked: NBANKS must be 1..8");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("intc_banked: SYNC_STAGES must be 1..4");
   end

   // ---------------- address decode ----------------
   logic [BANK_W-1:0] bank_sel;
   logic [7:0]        ofs;
   logic              bank_ok, bank0, is_cfg, rd_code;
   logic [4:0]        cfg_idx;
   logic [1:0]        ctrl_hit;

   assign bank_sel = bus_addr[ADDR_W-1:8];
   assign ofs      = bus_addr[7:0];
   assign bank_ok  = 32'(bank_sel) < NBANKS;
   assign bank0    = bank_ok && (bank_sel == '0);
   assign is_cfg   = (ofs >= OFS_CFG0) && (ofs <= OFS_CFG_LAST) && (ofs[1:0] == 2'b00);
   assign cfg_idx  = 5'((ofs - OFS_CFG0) >> 2);
   assign rd_code  = bus_re && bank0 && ((ofs == OFS_CODE_NRM) || (ofs == OFS_CODE_FST));
   assign ctrl_hit = (bus_we && bank0 && (ofs == OFS_CTRL)) ? bus_wdata[1:0] : 2'b00;

   // ---------------- input synchronizer ----------------
   logic [NLINES-1:0] in_s;
   intc_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(in_s));

   // ---------------- per-bank state ----------------
   logic [LINES_PER_BANK-1:0]        pend_b [NBANKS];
   logic [LINES_PER_BANK-1:0]        mask_b [NBANKS];
   logic [LINES_PER_BANK-1:0]        lvl_b  [NBANKS];
   logic [LINES_PER_BANK-1:0]        fast_b [NBANKS];
   logic [LINES_PER_BANK*PRIO_W-1:0] prio_b [NBANKS];
   logic [NLINES-1:0]                pend_all, mask_all, fast_all;
   logic [NLINES*PRIO_W-1:0]         prio_all;
   logic [IDX_W-1:0]                 code_q [2];
   logic [IDX_W-1:0]                 code_sel;

   assign code_sel = code_q[ofs[2]];

   for (genvar b = 0; b < int'(NBANKS); b++) begin : g_bank
      logic hit;
      logic [LINES_PER_BANK-1:0] ack_v;
      assign hit   = bank_ok && (32'(bank_sel) == 32'(b));
      assign ack_v = (rd_code && ((32'(code_sel) >> 5) == 32'(b)))
                     ? (32'd1 << code_sel[4:0]) : '0;

      intc_bank u_bank (
         .clk(clk), .rst_n(rst_n),
         .in_sync(in_s[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .wr_pend(bus_we && hit && (ofs == OFS_PEND)),
         .wr_mask(bus_we && hit && (ofs == OFS_MASK)),
         .wr_cfg (bus_we && hit && is_cfg),
         .wr_soft(bus_we && hit && (ofs == OFS_SOFT)),
         .cfg_idx(cfg_idx), .wdata(bus_wdata), .ack_clr(ack_v),
         .pend_o(pend_b[b]), .mask_o(mask_b[b]), .level_o(lvl_b[b]),
         .fast_o(fast_b[b]), .prio_o(prio_b[b]));

      assign pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]               = pend_b[b];
      assign mask_all[b*LINES_PER_BANK +: LINES_PER_BANK]               = mask_b[b];
      assign fast_all[b*LINES_PER_BANK +: LINES_PER_BANK]               = fast_b[b];
      assign prio_all[b*LINES_PER_BANK*PRIO_W +: LINES_PER_BANK*PRIO_W] = prio_b[b];
   end

   // ---------------- per-class arbitration ----------------
   logic [NLINES-1:0] elig_c [2];
   logic [1:0]        any_c;
   logic [IDX_W-1:0]  win_c [2];
   logic [1:0]        out_q, agree_q;

   assign elig_c[0] = pend_all & ~mask_all & ~fast_all;
   assign elig_c[1] = pend_all & ~mask_all &  fast_all;

   for (genvar c = 0; c < 2; c++) begin : g_cls
      intc_arbiter #(.N(NLINES)) u_arb (
         .clk(clk), .rst_n(rst_n), .elig(elig_c[c]), .prio(prio_all),
         .any_o(any_c[c]), .win_o(win_c[c]));

      // R7: once raised, a request holds until its own re-arm
      a_r7_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (out_q[c] && !ctrl_hit[c]) |=> out_q[c]);
      // R7: a request rises only with an eligible line
      a_r7_rise_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_q[c]) |-> $past(any_c[c]));
      // R8: re-arm drops the request on the next edge
      a_r8_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_hit[c] |=> !out_q[c]);
      // R7: latched code is stable while the request is held
      a_r7_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (out_q[c] && $past(out_q[c])) |-> $stable(code_q[c]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         agree_q <= '1;
         code_q[0] <= '0;
         code_q[1] <= '0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (ctrl_hit[c]) begin
               out_q[c]   <= 1'b0;
               agree_q[c] <= 1'b1;
            end else if (agree_q[c] && any_c[c]) begin
               out_q[c]   <= 1'b1;
               agree_q[c] <= 1'b0;
               code_q[c]  <= win_c[c];
            end
         end
      end
   end

   assign irq_out = out_q[0];
   assign fiq_out = out_q[1];

   // ---------------- read path ----------------
   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (bank_ok) begin
         case (ofs)
            OFS_PEND:                   rd_val = pend_b[bank_sel];
            OFS_MASK:                   rd_val = mask_b[bank_sel];
            OFS_CODE_NRM, OFS_CODE_FST: rd_val = bank0 ? {27'b0, code_sel[4:0]} : '0;
            OFS_CTRL, OFS_SOFT:         rd_val = '0;
            default: begin
               if (is_cfg)
                  rd_val = {25'b0, prio_b[bank_sel][int'(cfg_idx)*PRIO_W +: PRIO_W],
                            lvl_b[bank_sel][cfg_idx], fast_b[bank_sel][cfg_idx]};
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_val;
   end
endmodule

// File: tb/intc_banked_tb.sv
`timescale 1ns/1ps
module intc_banked_tb;
   localparam int NL = 64;
   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NL-1:0] irq_in;
   logic          we, re;
   logic [AW-1:0] addr;
   logic [31:0]   wdata, rdata, got;
   logic          irq_out, fiq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   intc_banked #(.NBANKS(2), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(we), .bus_re(re),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq_out(irq_out), .fiq_out(fiq_out));

   // {line_a, prio_a, line_b, prio_b, expected winner}
   localparam logic [27:0] VEC [5] = '{
      {6'd3,  5'd5,  6'd7,  5'd5,  6'd7 },
      {6'd3,  5'd2,  6'd7,  5'd9,  6'd3 },
      {6'd40, 5'd4,  6'd10, 5'd4,  6'd40},
      {6'd10, 5'd0,  6'd40, 5'd1,  6'd10},
      {6'd0,  5'd31, 6'd63, 5'd31, 6'd63}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input int ln);
      irq_in[ln] = 1'b1;
      idle(5);
      irq_in[ln] = 1'b0;
      idle(3);
   endtask

   function automatic logic [AW-1:0] cfg_addr(input int ln);
      return AW'((ln / 32) * 256 + 28 + 4 * (ln % 32));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq_in = '0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
      chk("R1 fiq_out", {31'b0, fiq_out}, 32'h0);
      rd(9'h004, got); chk("R1 mask bank0", got, 32'hFFFF_FFFF);
      rd(9'h104, got); chk("R1 mask bank1", got, 32'hFFFF_FFFF);
      rd(9'h000, got); chk("R1 pending", got, 32'h0);
      rd(9'h010, got); chk("R1 code", got, 32'h0);

      // R2 configuration word fields
      wr(cfg_addr(37), 32'h7F);
      rd(cfg_addr(37), got); chk("R2 cfg full", got, 32'h7F);
      wr(cfg_addr(37), 32'h0001_2345);
      rd(cfg_addr(37), got); chk("R2 cfg upper dropped", got, 32'h45);

      // R12 mask readback, software-set reads zero
      wr(9'h004, 32'hA5A5_0F0F);
      rd(9'h004, got); chk("R12 mask readback", got, 32'hA5A5_0F0F);
      rd(9'h09C, got); chk("R12 soft read", got, 32'h0);
      wr(9'h004, 32'h0);
      wr(9'h104, 32'h0);

      // R6/R7 table of arbitration cases
      for (int k = 0; k < 5; k++) begin
         logic [5:0] la, lb, ex;
         logic [4:0] pa, pb;
         la = VEC[k][27:22]; pa = VEC[k][21:17];
         lb = VEC[k][16:11]; pb = VEC[k][10:6]; ex = VEC[k][5:0];
         wr(cfg_addr(int'(la)), {25'b0, pa, 2'b00});
         wr(cfg_addr(int'(lb)), {25'b0, pb, 2'b00});
         wr(9'h000, 32'h0);
         wr(9'h100, 32'h0);
         irq_in[la] = 1'b1; irq_in[lb] = 1'b1;
         idle(5);
         irq_in[la] = 1'b0; irq_in[lb] = 1'b0;
         idle(3);
         wr(9'h018, 32'h1);
         idle(2);
         chk("R7 request up", {31'b0, irq_out}, 32'h1);
         rd(9'h010, got); chk("R6 winner code", got, {27'b0, ex[4:0]});
      end

      // R7 latched code held although a better line arrives
      wr(cfg_addr(12), 32'h0);
      pulse(12);
      rd(9'h010, got); chk("R7 code held", got, 32'd31);

      // R8 re-arm: one low cycle, then new winner
      wr(9'h018, 32'h1);
      chk("R8 dropped", {31'b0, irq_out}, 32'h0);
      idle(1);
      chk("R8 raised again", {31'b0, irq_out}, 32'h1);
      idle(1);
      rd(9'h010, got); chk("R8 new code", got, 32'd12);
      wr(9'h000, 32'h0);
      wr(9'h100, 32'h0);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R8 stays low when idle", {31'b0, irq_out}, 32'h0);

      // R3 edge-type capture and latency
      irq_in[2] = 1'b1;
      rd(9'h000, got); chk("R3 not yet pending", got, 32'h0);
      idle(2);
      rd(9'h000, got); chk("R3 pending after sync", got, 32'h4);
      wr(9'h000, 32'h0);
      idle(3);
      rd(9'h000, got); chk("R3 no re-set while held", got, 32'h0);
      irq_in[2] = 1'b0;
      idle(3);

      // R4/R5 level-type line 4 with edge line 6
      wr(cfg_addr(4), 32'h2);
      irq_in[4] = 1'b1; irq_in[6] = 1'b1;
      idle(5);
      irq_in[6] = 1'b0;
      idle(3);
      rd(9'h000, got); chk("R4 level and edge pending", got, 32'h50);
      wr(9'h000, 32'hFFFF_FFBF);
      rd(9'h000, got); chk("R5 AND clears edge bit", got, 32'h10);
      wr(9'h000, 32'h0);
      rd(9'h000, got); chk("R5 level bit kept", got, 32'h10);
      irq_in[4] = 1'b0;
      idle(4);
      rd(9'h000, got); chk("R4 level clears on fall", got, 32'h0);

      // R9 source-code read acknowledge
      wr(cfg_addr(9), 32'h4);
      irq_in[4] = 1'b1;
      pulse(9);
      wr(9'h018, 32'h1);
      idle(2);
      rd(9'h010, got); chk("R9 level winner code", got, 32'd4);
      rd(9'h000, got); chk("R9 level not cleared", got, 32'h210);
      irq_in[4] = 1'b0;
      idle(4);
      rd(9'h000, got); chk("R9 level gone", got, 32'h200);
      wr(9'h018, 32'h1);
      idle(2);
      rd(9'h010, got); chk("R9 edge winner code", got, 32'd9);
      rd(9'h000, got); chk("R9 edge cleared by read", got, 32'h0);

      // R10 bank-1 copies and unmapped offsets are inert
      pulse(9);
      rd(9'h110, got); chk("R10 bank1 code", got, 32'h0);
      rd(9'h118, got); chk("R10 bank1 ctrl", got, 32'h0);
      rd(9'h00C, got); chk("R10 unmapped", got, 32'h0);
      rd(9'h000, got); chk("R10 no side effect", got, 32'h200);

      // R6 fast class, R9 in-bank index of a bank-1 line
      wr(cfg_addr(52), 32'h1);
      pulse(52);
      chk("R6 fast request", {31'b0, fiq_out}, 32'h1);
      rd(9'h014, got); chk("R9 fast code", got, 32'd20);
      rd(9'h100, got); chk("R9 fast edge cleared", got, 32'h0);
      wr(9'h018, 32'h2);
      chk("R8 fast dropped", {31'b0, fiq_out}, 32'h0);
      chk("R8 normal untouched", {31'b0, irq_out}, 32'h1);

      // R11 software set, lowest bit only
      wr(9'h100, 32'h0);
      wr(9'h19C, 32'h0000_0300);
      rd(9'h100, got); chk("R11 lowest bit only", got, 32'h100);
      rd(9'h19C, got); chk("R12 soft read bank1", got, 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule